// File: doc/BRIEF.md
# Two-Cluster Stitched Store Forwarding Buffer

This block keeps the in-flight stores of two execution clusters that share one contiguous instruction window. One cluster holds the older batch of instructions, the other the younger batch, and each cluster has its own store queue. A store is allocated with a program-order tag. Its address and its data arrive later, in separate writes. A load presents its cluster, tag and word address. The block answers with forwarded data, a miss (go to memory) or a stall.

A load is first matched against the stores of its own cluster. If nothing there decides the result and the load sits in the younger cluster, the lookup moves on to the older cluster's queue. That answer comes one cycle later on a separate response channel. The older cluster's unknown-address summary also holds back younger loads, so the two queues behave as one buffer. Commits drain the older queue oldest-first. When the older queue empties through a commit, the two clusters swap roles. A tagged flush removes every store younger than the tag from both queues at once.

Tags are compared as plain unsigned numbers, so a smaller tag is older. Responses use the kind encoding MISS = 0, HIT = 1, STALL = 2.

Top module: `stitched_stlf`

## Requirements
- R1: After reset both queues are empty and `older_cl` is 0. A load in cluster 0 then answers MISS (kind 0) in the same cycle, and `xrsp_vld` stays 0.
- R2: A load whose address matches stores in its own cluster that are older than it (smaller tag) and whose data is known answers HIT (kind 1) in the same cycle. The data comes from the youngest such store. Stores with a tag equal to or greater than the load's tag are ignored.
- R3: If the youngest matching older store has a known address but no data yet, the response is STALL (kind 2) with data 0.
- R4: When `cons_mode` is 1, a load answers STALL in the same cycle if an older store in its own cluster has an unknown address. A load in the younger cluster also answers STALL if any store in the older cluster has an unknown address. This stall wins over any match. When `cons_mode` is 0, stores with unknown addresses are skipped.
- R5: A load in the older cluster with no matching older local store answers MISS in the same cycle.
- R6: A load in the younger cluster with no matching local store and no stall gives no same-cycle response (`rsp_vld` = 0). In the next cycle `xrsp_vld` is 1 and `xrsp_tag` carries the load's tag. The answer is taken from the youngest matching store of the older cluster: HIT with its data, STALL if its data is missing, MISS if there is none. With `cons_mode` set, the answer is STALL if the older cluster then holds an unknown-address store.
- R7: A local match is served in the cycle of the lookup, even when the older cluster also holds a matching store. No escalated response follows.
- R8: `commit_vld` removes the oldest store of the older cluster. Later loads no longer see that store, while its younger neighbours stay visible.
- R9: When a commit removes the last store of the older cluster, `older_cl` toggles in the next cycle. At no other time does it change.
- R10: `flush_vld` removes, within one cycle, every store in both queues whose tag is greater than `flush_tag`. It cancels an escalation started in the same cycle by a load younger than `flush_tag`, and it drops an allocation made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cons_mode | input | 1 | 1: conservative ordering against unknown-address stores |
| alloc_vld | input | 1 | Allocate a store |
| alloc_cl | input | 1 | Cluster receiving the store |
| alloc_tag | input | 4 | Program-order tag of the new store |
| st_addr_vld | input | 1 | Address write for a store |
| st_addr_tag | input | 4 | Tag of the store receiving the address |
| st_addr | input | 32 | Word address |
| st_data_vld | input | 1 | Data write for a store |
| st_data_tag | input | 4 | Tag of the store receiving the data |
| st_data | input | 32 | Store data |
| ld_vld | input | 1 | Load lookup |
| ld_cl | input | 1 | Cluster of the load |
| ld_tag | input | 4 | Program-order tag of the load |
| ld_addr | input | 32 | Load word address |
| commit_vld | input | 1 | Retire the oldest store of the older cluster |
| flush_vld | input | 1 | Flush younger stores |
| flush_tag | input | 4 | Stores with a greater tag are removed |
| rsp_vld | output | 1 | Same-cycle local response |
| rsp_kind | output | 2 | 0 MISS, 1 HIT, 2 STALL |
| rsp_data | output | 32 | Forwarded data on HIT, else 0 |
| xrsp_vld | output | 1 | Escalated response, one cycle after the lookup |
| xrsp_kind | output | 2 | 0 MISS, 1 HIT, 2 STALL |
| xrsp_tag | output | 4 | Tag of the escalated load |
| xrsp_data | output | 32 | Forwarded data on HIT, else 0 |
| older_cl | output | 1 | Cluster currently holding the older batch |

## Verification
A wrong entry state, such as a stale valid bit after a commit or flush or an address written to the wrong tag, shows up on the very next load to that address as a HIT that should be a MISS, or as the wrong data. A broken youngest-match choice shows as data from an older store in the same cycle as the lookup. A fault in the escalation register or the role bit shows one cycle later. It appears as a missing or misplaced `xrsp_vld`, a wrong `xrsp_tag`, or a load that answers locally when it should have escalated. The tests therefore pair every state change with loads that separate the neighbouring stores by address and by age.

// File: rtl/stlf_pkg.sv
`timescale 1ns/1ps
package stlf_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned TAG_W  = 4;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [TAG_W-1:0]  tag_t;

  typedef enum logic [1:0] {
    RSP_MISS  = 2'd0,
    RSP_HIT   = 2'd1,
    RSP_STALL = 2'd2
  } rsp_kind_e;

  typedef struct packed {
    logic  vld;
    logic  avld;
    logic  dvld;
    addr_t addr;
    data_t data;
    tag_t  tag;
  } sq_ent_t;

  // store with tag st precedes a load with tag ld in program order
  function automatic logic is_older(tag_t st, tag_t ld);
    return st < ld;
  endfunction

  // entry lies after the flush point
  function automatic logic is_younger(tag_t st, tag_t lim);
    return st > lim;
  endfunction
endpackage

// File: rtl/stlf_queue.sv
`timescale 1ns/1ps
module stlf_queue
  import stlf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    alloc_en,
  input  tag_t    alloc_tag,
  input  logic    aw_en,
  input  tag_t    aw_tag,
  input  addr_t   aw_addr,
  input  logic    dw_en,
  input  tag_t    dw_tag,
  input  data_t   dw_data,
  input  logic    commit_en,
  input  logic    flush_en,
  input  tag_t    flush_tag,
  output sq_ent_t ents [DEPTH],
  output logic    unk_any,
  output logic    commit_last
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             old_found;
  logic [IDX_W-1:0] old_idx;
  tag_t             old_tag;
  logic [CNT_W-1:0] n_vld;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ents[i].vld) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    old_found = 1'b0;
    old_idx   = '0;
    old_tag   = '0;
    n_vld     = '0;
    unk_any   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ents[i].vld) begin
        n_vld = n_vld + 1'b1;
        if (!ents[i].avld) unk_any = 1'b1;
        if (!old_found || ents[i].tag < old_tag) begin
          old_found = 1'b1;
          old_idx   = IDX_W'(i);
          old_tag   = ents[i].tag;
        end
      end
    end
  end

  assign commit_last = commit_en && (n_vld == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (flush_en && ents[i].vld && is_younger(ents[i].tag, flush_tag)) begin
          ents[i].vld <= 1'b0;
        end else begin
          if (aw_en && ents[i].vld && ents[i].tag == aw_tag) begin
            ents[i].avld <= 1'b1;
            ents[i].addr <= aw_addr;
          end
          if (dw_en && ents[i].vld && ents[i].tag == dw_tag) begin
            ents[i].dvld <= 1'b1;
            ents[i].data <= dw_data;
          end
          if (commit_en && old_found && IDX_W'(i) == old_idx) ents[i].vld <= 1'b0;
        end
      end
      if (alloc_en && !flush_en && free_found) begin
        ents[free_idx] <= '{vld: 1'b1, avld: 1'b0, dvld: 1'b0,
                            addr: '0, data: '0, tag: alloc_tag};
      end
    end
  end
endmodule

// File: rtl/stlf_search.sv
`timescale 1ns/1ps
module stlf_search
  import stlf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  sq_ent_t ents [DEPTH],
  input  addr_t   addr,
  input  tag_t    tag,
  input  logic    bounded,
  output logic    hit,
  output logic    hit_dvld,
  output data_t   hit_data,
  output logic    unk_older
);
  tag_t best_tag;
  logic older;

  always_comb begin
    hit       = 1'b0;
    hit_dvld  = 1'b0;
    hit_data  = '0;
    unk_older = 1'b0;
    best_tag  = '0;
    older     = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      older = ents[i].vld && (!bounded || is_older(ents[i].tag, tag));
      if (older && !ents[i].avld) unk_older = 1'b1;
      if (older && ents[i].avld && ents[i].addr == addr &&
          (!hit || ents[i].tag > best_tag)) begin
        hit      = 1'b1;
        best_tag = ents[i].tag;
        hit_dvld = ents[i].dvld;
        hit_data = ents[i].data;
      end
    end
  end
endmodule

// File: rtl/stitched_stlf.sv
`timescale 1ns/1ps
module stitched_stlf
  import stlf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cons_mode,
  input  logic              alloc_vld,
  input  logic              alloc_cl,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              st_addr_vld,
  input  logic [TAG_W-1:0]  st_addr_tag,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_data_vld,
  input  logic [TAG_W-1:0]  st_data_tag,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_vld,
  input  logic              ld_cl,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              commit_vld,
  input  logic              flush_vld,
  input  logic [TAG_W-1:0]  flush_tag,
  output logic              rsp_vld,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic              xrsp_vld,
  output logic [1:0]        xrsp_kind,
  output logic [TAG_W-1:0]  xrsp_tag,
  output logic [DATA_W-1:0] xrsp_data,
  output logic              older_cl
);
  localparam int unsigned NCL = 2;

  sq_ent_t          ents_c [NCL][DEPTH];
  logic [NCL-1:0]   unk_c;
  logic [NCL-1:0]   clast_c;
  logic             older_q;

  for (genvar c = 0; c < NCL; c++) begin : g_cl
    stlf_queue #(.DEPTH(DEPTH)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_vld && (alloc_cl == 1'(c))),
      .alloc_tag  (alloc_tag),
      .aw_en      (st_addr_vld),
      .aw_tag     (st_addr_tag),
      .aw_addr    (st_addr),
      .dw_en      (st_data_vld),
      .dw_tag     (st_data_tag),
      .dw_data    (st_data),
      .commit_en  (commit_vld && (older_q == 1'(c))),
      .flush_en   (flush_vld),
      .flush_tag  (flush_tag),
      .ents       (ents_c[c]),
      .unk_any    (unk_c[c]),
      .commit_last(clast_c[c])
    );
  end

  // events brought out for the checker
  logic older_unk;
  logic commit_last;
  assign older_unk   = unk_c[older_q];
  assign commit_last = clast_c[older_q];

  // local lookup in the load's own cluster
  sq_ent_t loc_ents [DEPTH];
  logic    loc_hit, loc_dvld, loc_unk;
  data_t   loc_data;
  always_comb for (int i = 0; i < DEPTH; i++) loc_ents[i] = ld_cl ? ents_c[1][i] : ents_c[0][i];

  stlf_search #(.DEPTH(DEPTH)) u_loc (
    .ents(loc_ents), .addr(ld_addr), .tag(ld_tag), .bounded(1'b1),
    .hit(loc_hit), .hit_dvld(loc_dvld), .hit_data(loc_data), .unk_older(loc_unk)
  );

  logic ld_young, stall_c, esc_go;
  assign ld_young = (ld_cl != older_q);
  assign stall_c  = cons_mode && (loc_unk || (ld_young && older_unk));

  always_comb begin
    rsp_vld  = 1'b0;
    rsp_kind = RSP_MISS;
    rsp_data = '0;
    esc_go   = 1'b0;
    if (ld_vld) begin
      if (stall_c) begin
        rsp_vld  = 1'b1;
        rsp_kind = RSP_STALL;
      end else if (loc_hit) begin
        rsp_vld  = 1'b1;
        rsp_kind = loc_dvld ? RSP_HIT : RSP_STALL;
        rsp_data = loc_dvld ? loc_data : '0;
      end else if (!ld_young) begin
        rsp_vld  = 1'b1;
        rsp_kind = RSP_MISS;
      end else begin
        esc_go = 1'b1;
      end
    end
  end

  // escalation stage: one registered cycle toward the older cluster
  logic  esc_pend_q, esc_cl_q;
  addr_t esc_addr_q;
  tag_t  esc_tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      esc_pend_q <= 1'b0;
      esc_cl_q   <= 1'b0;
      esc_addr_q <= '0;
      esc_tag_q  <= '0;
      older_q    <= 1'b0;
    end else begin
      esc_pend_q <= esc_go && !(flush_vld && is_younger(ld_tag, flush_tag));
      if (esc_go) begin
        esc_cl_q   <= older_q;
        esc_addr_q <= ld_addr;
        esc_tag_q  <= ld_tag;
      end
      if (commit_last) older_q <= !older_q;
    end
  end

  sq_ent_t rem_ents [DEPTH];
  logic    rem_hit, rem_dvld, rem_unk;
  data_t   rem_data;
  always_comb for (int i = 0; i < DEPTH; i++) rem_ents[i] = esc_cl_q ? ents_c[1][i] : ents_c[0][i];

  stlf_search #(.DEPTH(DEPTH)) u_rem (
    .ents(rem_ents), .addr(esc_addr_q), .tag(esc_tag_q), .bounded(1'b0),
    .hit(rem_hit), .hit_dvld(rem_dvld), .hit_data(rem_data), .unk_older(rem_unk)
  );

  always_comb begin
    xrsp_vld  = esc_pend_q;
    xrsp_tag  = esc_tag_q;
    xrsp_data = '0;
    if (cons_mode && rem_unk)  xrsp_kind = RSP_STALL;
    else if (!rem_hit)         xrsp_kind = RSP_MISS;
    else if (!rem_dvld)        xrsp_kind = RSP_STALL;
    else begin
      xrsp_kind = RSP_HIT;
      xrsp_data = rem_data;
    end
  end

  assign older_cl = older_q;
endmodule

// File: rtl/stitched_stlf_chk.sv
`timescale 1ns/1ps
module stitched_stlf_chk
  import stlf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cons_mode,
  input logic       ld_vld,
  input tag_t       ld_tag,
  input logic       loc_unk,
  input logic       flush_vld,
  input tag_t       flush_tag,
  input logic       rsp_vld,
  input logic [1:0] rsp_kind,
  input logic       xrsp_vld,
  input logic       esc_go,
  input logic       commit_last,
  input logic       older_cl,
  input sq_ent_t    ents_c [2][DEPTH]
);
  tag_t flush_tag_q;
  logic young_left;

  always_ff @(posedge clk) flush_tag_q <= flush_tag;

  always_comb begin
    young_left = 1'b0;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < DEPTH; i++)
        if (ents_c[c][i].vld && ents_c[c][i].tag > flush_tag_q) young_left = 1'b1;
  end

  p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (rsp_kind != 2'd3));
  p_cons_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_mode && ld_vld && loc_unk) |-> (rsp_vld && rsp_kind == 2'd2));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_vld |-> !rsp_vld);
  p_rsp_or_esc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |-> (rsp_vld != esc_go));
  p_esc_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_go && !(flush_vld && ld_tag > flush_tag)) |=> xrsp_vld);
  p_xrsp_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xrsp_vld |-> $past(esc_go));
  p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_last |=> (older_cl != $past(older_cl)));
  p_role_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_last |=> $stable(older_cl));
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |=> !young_left);
endmodule

bind stitched_stlf stitched_stlf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cons_mode  (cons_mode),
  .ld_vld     (ld_vld),
  .ld_tag     (ld_tag),
  .loc_unk    (loc_unk),
  .flush_vld  (flush_vld),
  .flush_tag  (flush_tag),
  .rsp_vld    (rsp_vld),
  .rsp_kind   (rsp_kind),
  .xrsp_vld   (xrsp_vld),
  .esc_go     (esc_go),
  .commit_last(commit_last),
  .older_cl   (older_cl),
  .ents_c     (ents_c)
);

// File: tb/test_stitched_stlf.sv
`timescale 1ns/1ps
module test_stitched_stlf;
  localparam logic [1:0] K_MISS = 2'd0, K_HIT = 2'd1, K_STALL = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cons_mode = 1'b1;
  logic        alloc_vld = 0, alloc_cl = 0;
  logic [3:0]  alloc_tag = 0;
  logic        st_addr_vld = 0;
  logic [3:0]  st_addr_tag = 0;
  logic [31:0] st_addr = 0;
  logic        st_data_vld = 0;
  logic [3:0]  st_data_tag = 0;
  logic [31:0] st_data = 0;
  logic        ld_vld = 0, ld_cl = 0;
  logic [3:0]  ld_tag = 0;
  logic [31:0] ld_addr = 0;
  logic        commit_vld = 0, flush_vld = 0;
  logic [3:0]  flush_tag = 0;
  logic        rsp_vld, xrsp_vld, older_cl;
  logic [1:0]  rsp_kind, xrsp_kind;
  logic [31:0] rsp_data, xrsp_data;
  logic [3:0]  xrsp_tag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stitched_stlf i_stitched_stlf (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one-cycle strobes, driven at the falling edge
  task automatic alloc(logic cl, logic [3:0] tag);
    @(negedge clk); alloc_vld = 1; alloc_cl = cl; alloc_tag = tag;
    @(posedge clk); #1 alloc_vld = 0;
  endtask
  task automatic waddr(logic [3:0] tag, logic [31:0] a);
    @(negedge clk); st_addr_vld = 1; st_addr_tag = tag; st_addr = a;
    @(posedge clk); #1 st_addr_vld = 0;
  endtask
  task automatic wdata(logic [3:0] tag, logic [31:0] d);
    @(negedge clk); st_data_vld = 1; st_data_tag = tag; st_data = d;
    @(posedge clk); #1 st_data_vld = 0;
  endtask
  task automatic store(logic cl, logic [3:0] tag, bit av, logic [31:0] a, bit dv, logic [31:0] d);
    alloc(cl, tag);
    if (av) waddr(tag, a);
    if (dv) wdata(tag, d);
  endtask
  task automatic commit();
    @(negedge clk); commit_vld = 1;
    @(posedge clk); #1 commit_vld = 0;
  endtask
  task automatic flush(logic [3:0] tag);
    @(negedge clk); flush_vld = 1; flush_tag = tag;
    @(posedge clk); #1 flush_vld = 0;
  endtask

  // load with same-cycle check; leaves time just after the next rising edge
  task automatic load(string req, logic cl, logic [3:0] tag, logic [31:0] a,
                      logic ev, logic [1:0] ek, logic [31:0] ed);
    @(negedge clk); ld_vld = 1; ld_cl = cl; ld_tag = tag; ld_addr = a;
    #2;
    check(req, "rsp_vld", 32'(rsp_vld), 32'(ev));
    if (ev) begin
      check(req, "rsp_kind", 32'(rsp_kind), 32'(ek));
      check(req, "rsp_data", rsp_data, ed);
    end
    @(posedge clk); #1 ld_vld = 0;
  endtask

  // escalated response, sampled in the cycle after the load
  task automatic xcheck(string req, logic ev, logic [1:0] ek, logic [31:0] ed, logic [3:0] et);
    #2;
    check(req, "xrsp_vld", 32'(xrsp_vld), 32'(ev));
    if (ev) begin
      check(req, "xrsp_kind", 32'(xrsp_kind), 32'(ek));
      check(req, "xrsp_data", xrsp_data, ed);
      check(req, "xrsp_tag", 32'(xrsp_tag), 32'(et));
    end
  endtask

  task automatic t_reset();
    do_reset();
    #2 check("R1", "older_cl", 32'(older_cl), 0);
    load("R1", 0, 4'd5, 32'h10, 1, K_MISS, 0);
    xcheck("R1", 0, K_MISS, 0, 0);
  endtask

  task automatic t_local_hit();
    do_reset(); cons_mode = 1;
    store(0, 4'd1, 1, 32'h40, 1, 32'hA1);
    store(0, 4'd2, 1, 32'h40, 1, 32'hB2);
    store(0, 4'd3, 1, 32'h40, 1, 32'hC3);
    load("R2", 0, 4'd3, 32'h40, 1, K_HIT, 32'hB2);
    load("R2", 0, 4'd2, 32'h40, 1, K_HIT, 32'hA1);
    load("R2", 0, 4'd9, 32'h40, 1, K_HIT, 32'hC3);
  endtask

  task automatic t_data_stall();
    do_reset(); cons_mode = 1;
    store(0, 4'd1, 1, 32'h50, 1, 32'h11);
    store(0, 4'd2, 1, 32'h50, 0, 0);
    load("R3", 0, 4'd3, 32'h50, 1, K_STALL, 0);
  endtask

  task automatic t_cons();
    do_reset(); cons_mode = 1;
    store(0, 4'd1, 1, 32'h40, 1, 32'h77);
    store(0, 4'd2, 0, 0, 0, 0);
    load("R4", 0, 4'd3, 32'h40, 1, K_STALL, 0);
    cons_mode = 0;
    load("R4", 0, 4'd3, 32'h40, 1, K_HIT, 32'h77);
    do_reset(); cons_mode = 1;
    store(0, 4'd1, 0, 0, 0, 0);
    load("R4", 1, 4'd8, 32'h99, 1, K_STALL, 0);
    cons_mode = 0;
    load("R4", 1, 4'd8, 32'h99, 0, K_MISS, 0);
    xcheck("R4", 1, K_MISS, 0, 4'd8);
    cons_mode = 1;
  endtask

  task automatic t_old_miss();
    do_reset();
    store(0, 4'd1, 1, 32'h60, 1, 32'h5);
    load("R5", 0, 4'd4, 32'h64, 1, K_MISS, 0);
    xcheck("R5", 0, K_MISS, 0, 0);
  endtask

  task automatic t_escalate();
    do_reset(); cons_mode = 1;
    store(0, 4'd1, 1, 32'h80, 1, 32'h1111);
    store(0, 4'd2, 1, 32'h80, 0, 0);
    store(1, 4'd9, 1, 32'h20, 1, 32'h9999);
    load("R6", 1, 4'd10, 32'h80, 0, K_MISS, 0);
    xcheck("R6", 1, K_STALL, 0, 4'd10);
    wdata(4'd2, 32'h2222);
    load("R6", 1, 4'd11, 32'h80, 0, K_MISS, 0);
    xcheck("R6", 1, K_HIT, 32'h2222, 4'd11);
    load("R6", 1, 4'd12, 32'h300, 0, K_MISS, 0);
    xcheck("R6", 1, K_MISS, 0, 4'd12);
  endtask

  task automatic t_local_priority();
    do_reset(); cons_mode = 1;
    store(0, 4'd1, 1, 32'h80, 1, 32'hD1);
    store(1, 4'd9, 1, 32'h80, 1, 32'hE9);
    load("R7", 1, 4'd10, 32'h80, 1, K_HIT, 32'hE9);
    xcheck("R7", 0, K_MISS, 0, 0);
  endtask

  task automatic t_commit();
    do_reset(); cons_mode = 1;
    store(0, 4'd1, 1, 32'hA0, 1, 32'hD1);
    store(0, 4'd2, 1, 32'hB0, 1, 32'hD2);
    commit();
    load("R8", 0, 4'd3, 32'hA0, 1, K_MISS, 0);
    load("R8", 0, 4'd3, 32'hB0, 1, K_HIT, 32'hD2);
    #2 check("R9", "older_cl held", 32'(older_cl), 0);
    commit();
    #2 check("R9", "older_cl swapped", 32'(older_cl), 1);
    load("R9", 1, 4'd10, 32'hB0, 1, K_MISS, 0);
    xcheck("R9", 0, K_MISS, 0, 0);
  endtask

  task automatic t_flush();
    do_reset(); cons_mode = 1;
    store(0, 4'd1, 1, 32'hC0, 1, 32'h11);
    store(0, 4'd2, 1, 32'hC0, 1, 32'h22);
    store(0, 4'd3, 1, 32'hC0, 1, 32'h33);
    store(1, 4'd9, 1, 32'hC0, 1, 32'h99);
    flush(4'd2);
    load("R10", 0, 4'd4, 32'hC0, 1, K_HIT, 32'h22);
    load("R10", 1, 4'd10, 32'hC0, 0, K_MISS, 0);
    xcheck("R10", 1, K_HIT, 32'h22, 4'd10);
    // escalation and flush in the same cycle
    @(negedge clk);
    ld_vld = 1; ld_cl = 1; ld_tag = 4'd12; ld_addr = 32'hC0;
    flush_vld = 1; flush_tag = 4'd11;
    alloc_vld = 1; alloc_cl = 1; alloc_tag = 4'd5;
    @(posedge clk); #1 ld_vld = 0; flush_vld = 0; alloc_vld = 0;
    xcheck("R10", 0, K_MISS, 0, 0);
    // the dropped allocation must not appear: address write then load sees nothing
    waddr(4'd5, 32'hE0);
    wdata(4'd5, 32'h55);
    load("R10", 1, 4'd6, 32'hE0, 0, K_MISS, 0);
    xcheck("R10", 1, K_MISS, 0, 4'd6);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_local_hit();
    t_data_stall();
    t_cons();
    t_old_miss();
    t_escalate();
    t_local_priority();
    t_commit();
    t_flush();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule